// File: doc/BRIEF.md
# Slicer Error Backpropagation Unit

This block takes the real-valued output of a fixed feed-forward equalizer, one sample per symbol, and decides each sample against a four-level amplitude grid. The difference between the sample and its decision is the symbol-rate error. That error is brought back to the sample rate of the equalizer's input in two steps. First, zeros are inserted to reach the oversampled rate. Then the stream is correlated with the equalizer's own coefficient vector, which is the same as running it through that filter with its taps in reverse order.

The result is an oversampled error stream. Each sample is tagged with the interleave branch it belongs to at the upstream stage's output, so an upstream compensation stage can adapt per branch.

The coefficients sit in a small register file. A freeze input holds that file fixed while calibration runs.

Top module: `slicer_err_backprop`

## Requirements
- R1: The slicer decides an input y against the levels -3L, -L, +L and +3L, with L = 512. The rule is: y >= 2L gives +3L; 0 <= y < 2L gives +L; -2L <= y < 0 gives -L; y < -2L gives -3L. A value sitting exactly on a threshold takes the upper level.
- R2: The symbol error is y minus the decision, computed in one bit more than the input width so that it never wraps.
- R3: Each accepted symbol produces OSR = 2 oversampled samples on consecutive cycles: its error first, then OSR-1 zero samples. Symbols must arrive at least OSR cycles apart.
- R4: For every oversampled sample the output is the sum over k = 0..7 of h[k]*u[n-7+k]. Here u is the upsampled stream and h[k] is the coefficient at address k. The newest sample is therefore weighted by h[7].
- R5: Coefficients are signed 12-bit with 10 fraction bits. The sum is arithmetically shifted right by 10 (rounding toward minus infinity) and saturated to the signed 16-bit range [-32768, 32767].
- R6: The error sample of a symbol appears with err_valid three cycles after the cycle in which sym_valid is high. Its zero sample appears one cycle later.
- R7: err_branch tags each valid output with a count modulo 4. The count starts at 0 after reset and increments by one per valid output.
- R8: A write (coef_we with coef_addr and coef_wdata) updates the coefficient at that address when freeze is low. When freeze is high, the write is ignored.
- R9: Reset is synchronous and active high. It clears all coefficients to zero, the sample history, err_valid, err_out and the branch count.
- R10: err_out is zero in every cycle in which err_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Equalizer output sample present |
| sym_in | input | 14 | Signed equalizer output |
| freeze | input | 1 | Holds the coefficient file, blocking writes |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 3 | Coefficient tap address |
| coef_wdata | input | 12 | Signed coefficient value, 10 fraction bits |
| err_valid | output | 1 | Oversampled error sample present |
| err_out | output | 16 | Signed backpropagated error, saturated |
| err_branch | output | 2 | Interleave branch index of the sample |

## Verification
The bench targets the slicer thresholds at 0 and at plus and minus 2L, plus both ends of the input range. A design that settles ties the wrong way, or lets the error wrap, returns an error of the wrong sign or size. A single unit tap at address 7 shows the zero-insertion sample and the tap order directly: a reversed filter, or a missing zero, moves energy into the wrong cycle. Large coefficients with full-scale inputs drive the sum past 16 bits in both directions, which exposes any wrapping accumulator. Writes issued under freeze must leave the output unchanged, and a later unfrozen write must change it.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

  typedef enum logic [1:0] {LV_N3, LV_N1, LV_P1, LV_P3} pam4_lvl_e;

  // Integer multiple of the base level for each decision
  function automatic int lvl_weight(pam4_lvl_e l);
    case (l)
      LV_N3:   return -3;
      LV_N1:   return -1;
      LV_P1:   return 1;
      default: return 3;
    endcase
  endfunction

  // Cycles from sym_valid to the first error sample on the outputs
  localparam int BPU_LAT = 3;

endpackage

// File: rtl/bpu_slicer_up.sv
module bpu_slicer_up
  import bpu_pkg::*;
#(
  parameter int IW  = 14,
  parameter int LVL = 512,
  parameter int OSR = 2,
  parameter int EW  = IW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sym_valid,
  input  logic signed [IW-1:0] sym_in,
  output logic                 u_valid,
  output logic signed [EW-1:0] u_data
);
  localparam int ZW = $clog2(OSR) + 1;
  localparam logic signed [EW-1:0] THR = EW'(2 * LVL);

  logic signed [EW-1:0] y_ext, dec, err;
  pam4_lvl_e            lvl;
  logic [ZW-1:0]        zcnt;

  always_comb begin
    y_ext = EW'(sym_in);
    if (y_ext >= THR)       lvl = LV_P3;
    else if (y_ext >= 0)    lvl = LV_P1;
    else if (y_ext >= -THR) lvl = LV_N1;
    else                    lvl = LV_N3;
    dec = EW'(lvl_weight(lvl) * LVL);
    err = y_ext - dec;
  end

  // Zero insertion: error first, then OSR-1 zero samples
  always_ff @(posedge clk) begin
    if (rst) begin
      u_valid <= 1'b0;
      u_data  <= '0;
      zcnt    <= '0;
    end else if (sym_valid) begin
      u_valid <= 1'b1;
      u_data  <= err;
      zcnt    <= ZW'(OSR - 1);
    end else if (zcnt != '0) begin
      u_valid <= 1'b1;
      u_data  <= '0;
      zcnt    <= zcnt - 1'b1;
    end else begin
      u_valid <= 1'b0;
      u_data  <= '0;
    end
  end

endmodule

// File: rtl/bpu_coef_rf.sv
module bpu_coef_rf #(
  parameter int NTAP = 8,
  parameter int CW   = 12,
  parameter int AW   = $clog2(NTAP)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               freeze,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [CW-1:0]      wdata,
  output logic [NTAP*CW-1:0] coef_flat
);
  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    logic [CW-1:0] coef_r;
    always_ff @(posedge clk) begin
      if (rst)
        coef_r <= '0;
      else if (we && !freeze && addr == AW'(t))
        coef_r <= wdata;
    end
    assign coef_flat[t*CW +: CW] = coef_r;
  end

endmodule

// File: rtl/bpu_corr.sv
module bpu_corr #(
  parameter int NTAP = 8,
  parameter int CW   = 12,
  parameter int EW   = 15,
  parameter int OW   = 16,
  parameter int FRAC = 10,
  parameter int NBR  = 4,
  parameter int BW   = $clog2(NBR)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [EW-1:0] in_data,
  input  logic [NTAP*CW-1:0]   coef_flat,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data,
  output logic [BW-1:0]        out_branch
);
  localparam int AW = EW + CW + $clog2(NTAP);
  localparam logic signed [AW-1:0] OMAX = AW'((2 ** (OW - 1)) - 1);
  localparam logic signed [AW-1:0] OMIN = AW'(-(2 ** (OW - 1)));

  logic signed [CW-1:0] cf   [NTAP];
  logic signed [EW-1:0] sreg [NTAP];
  logic                 s_vld;
  logic signed [AW-1:0] acc, shifted, ck, sk;
  logic [BW-1:0]        brc;

  for (genvar k = 0; k < NTAP; k++) begin : g_unpack
    assign cf[k] = coef_flat[k*CW +: CW];
  end

  // History of upsampled samples, sreg[0] newest
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAP; i++) sreg[i] <= '0;
      s_vld <= 1'b0;
    end else begin
      s_vld <= in_valid;
      if (in_valid) begin
        sreg[0] <= in_data;
        for (int i = 1; i < NTAP; i++) sreg[i] <= sreg[i-1];
      end
    end
  end

  // Correlation: h[k] weights the sample k places after the oldest
  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAP; k++) begin
      ck  = AW'(cf[k]);
      sk  = AW'(sreg[NTAP-1-k]);
      acc = acc + ck * sk;
    end
    shifted = acc >>> FRAC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_branch <= '0;
      brc        <= '0;
    end else begin
      out_valid <= s_vld;
      if (s_vld) begin
        if (shifted > OMAX)      out_data <= OMAX[OW-1:0];
        else if (shifted < OMIN) out_data <= OMIN[OW-1:0];
        else                     out_data <= shifted[OW-1:0];
        out_branch <= brc;
        brc        <= (brc == BW'(NBR - 1)) ? '0 : brc + 1'b1;
      end else begin
        out_data <= '0;
      end
    end
  end

endmodule

// File: rtl/slicer_err_backprop.sv
module slicer_err_backprop #(
  parameter int IW   = 14,
  parameter int LVL  = 512,
  parameter int OSR  = 2,
  parameter int NTAP = 8,
  parameter int CW   = 12,
  parameter int FRAC = 10,
  parameter int OW   = 16,
  parameter int NBR  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sym_valid,
  input  logic signed [IW-1:0]          sym_in,
  input  logic                          freeze,
  input  logic                          coef_we,
  input  logic [$clog2(NTAP)-1:0]       coef_addr,
  input  logic [CW-1:0]                 coef_wdata,
  output logic                          err_valid,
  output logic signed [OW-1:0]          err_out,
  output logic [$clog2(NBR)-1:0]        err_branch
);
  localparam int EW = IW + 1;

  logic                 u_valid;
  logic signed [EW-1:0] u_data;
  logic [NTAP*CW-1:0]   coef_flat;

  bpu_slicer_up #(.IW(IW), .LVL(LVL), .OSR(OSR), .EW(EW)) u_slice (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_in(sym_in),
    .u_valid(u_valid), .u_data(u_data)
  );

  bpu_coef_rf #(.NTAP(NTAP), .CW(CW)) u_coef (
    .clk(clk), .rst(rst), .freeze(freeze), .we(coef_we),
    .addr(coef_addr), .wdata(coef_wdata), .coef_flat(coef_flat)
  );

  bpu_corr #(.NTAP(NTAP), .CW(CW), .EW(EW), .OW(OW), .FRAC(FRAC), .NBR(NBR)) u_corr (
    .clk(clk), .rst(rst), .in_valid(u_valid), .in_data(u_data),
    .coef_flat(coef_flat), .out_valid(err_valid), .out_data(err_out),
    .out_branch(err_branch)
  );

endmodule

// File: rtl/slicer_err_backprop_chk.sv
module slicer_err_backprop_chk #(
  parameter int NTAP = 8,
  parameter int CW   = 12,
  parameter int OW   = 16,
  parameter int NBR  = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sym_valid,
  input logic                     freeze,
  input logic                     err_valid,
  input logic [OW-1:0]            err_out,
  input logic [$clog2(NBR)-1:0]   err_branch,
  input logic [NTAP*CW-1:0]       coef_flat
);
  localparam int BW = $clog2(NBR);

  logic          seen;
  logic [BW-1:0] last_br;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen    <= 1'b0;
      last_br <= '0;
    end else if (err_valid) begin
      seen    <= 1'b1;
      last_br <= err_branch;
    end
  end

  p_err_latency_r6: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> ##3 err_valid);

  p_zero_slot_r3: assert property (@(posedge clk) disable iff (rst)
    sym_valid |-> ##4 err_valid);

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !err_valid |-> err_out == '0);

  p_branch_step_r7: assert property (@(posedge clk) disable iff (rst)
    (err_valid && seen) |->
      err_branch == ((last_br == BW'(NBR - 1)) ? '0 : last_br + 1'b1));

  p_freeze_hold_r8: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(coef_flat));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!err_valid && err_branch == '0));

endmodule

bind slicer_err_backprop slicer_err_backprop_chk #(
  .NTAP(NTAP), .CW(CW), .OW(OW), .NBR(NBR)
) u_chk (
  .clk(clk), .rst(rst), .sym_valid(sym_valid), .freeze(freeze),
  .err_valid(err_valid), .err_out(err_out), .err_branch(err_branch),
  .coef_flat(coef_flat)
);

// File: tb/slicer_err_backprop_tb.sv
module slicer_err_backprop_tb;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sym_valid = 1'b0;
  logic signed [13:0] sym_in = '0;
  logic              freeze = 1'b0;
  logic              coef_we = 1'b0;
  logic [2:0]        coef_addr = '0;
  logic [11:0]       coef_wdata = '0;
  logic              err_valid;
  logic signed [15:0] err_out;
  logic [1:0]        err_branch;

  slicer_err_backprop u_dut (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_in(sym_in),
    .freeze(freeze), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_wdata(coef_wdata), .err_valid(err_valid), .err_out(err_out),
    .err_branch(err_branch)
  );

  always #5 clk = ~clk;

  typedef struct packed { logic signed [15:0] y; logic signed [15:0] e; } vec_t;
  // Input and expected error, unit tap at address 7 (R1, R2)
  localparam vec_t VEC [12] = '{
    '{16'sd0,     -16'sd512}, '{-16'sd1,    16'sd511},
    '{16'sd1023,  16'sd511},  '{16'sd1024,  -16'sd512},
    '{-16'sd1024, -16'sd512}, '{-16'sd1025, 16'sd511},
    '{16'sd8191,  16'sd6655}, '{-16'sd8192, -16'sd6656},
    '{16'sd1600,  16'sd64},   '{-16'sd300,  16'sd212},
    '{16'sd700,   16'sd188},  '{-16'sd2000, -16'sd464}
  };

  int nchk = 0, nfail = 0;
  int cnt = 0;
  bit mon_en = 0, done = 0;
  string cur_req = "R9";
  bit  exp_v [4096];
  int  exp_d [4096];
  int  exp_b [4096];
  int  bh [8];
  int  mdl [8];
  int  nb = 0;

  always @(posedge clk) cnt <= cnt + 1;

  function automatic int slice_ref(int y);
    if (y >= 1024) return 1536;
    if (y >= 0) return 512;
    if (y >= -1024) return -512;
    return -1536;
  endfunction

  function automatic int shift_model(int u);
    longint s = 0;
    for (int i = 7; i > 0; i--) mdl[i] = mdl[i-1];
    mdl[0] = u;
    for (int k = 0; k < 8; k++) s += longint'(bh[k]) * longint'(mdl[7-k]);
    s = s >>> 10;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  task automatic push(input int y, input bit use_tab, input int tab_e);
    int k, z1, z2;
    @(negedge clk);
    k = cnt;
    sym_valid = 1'b1;
    sym_in = 14'(y);
    z1 = shift_model(y - slice_ref(y));
    z2 = shift_model(0);
    exp_v[k+3] = 1'b1; exp_d[k+3] = use_tab ? tab_e : z1; exp_b[k+3] = nb; nb = (nb + 1) % 4;
    exp_v[k+4] = 1'b1; exp_d[k+4] = z2;                    exp_b[k+4] = nb; nb = (nb + 1) % 4;
    @(negedge clk);
    sym_valid = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = 3'(a); coef_wdata = 12'(d);
    if (!freeze) bh[a] = d;
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: 2 ns after each rising edge
  always begin
    @(posedge clk);
    #2;
    if (mon_en) begin
      nchk++;
      if (err_valid !== exp_v[cnt]) begin
        nfail++;
        $display("FAIL R6 cycle %0d: err_valid=%0b expected %0b", cnt, err_valid, exp_v[cnt]);
      end else if (!err_valid && err_out !== 16'sd0) begin
        nfail++;
        $display("FAIL R10 cycle %0d: err_out=%0d expected 0", cnt, err_out);
      end else if (err_valid && int'(err_out) != exp_d[cnt]) begin
        nfail++;
        $display("FAIL %s cycle %0d: err_out=%0d expected %0d", cur_req, cnt, err_out, exp_d[cnt]);
      end else if (err_valid && int'(err_branch) != exp_b[cnt]) begin
        nfail++;
        $display("FAIL R7 cycle %0d: err_branch=%0d expected %0d", cnt, err_branch, exp_b[cnt]);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired: done=0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin bh[i] = 0; mdl[i] = 0; end
    for (int i = 0; i < 4096; i++) begin exp_v[i] = 0; exp_d[i] = 0; exp_b[i] = 0; end
    idle(4);
    // R9: reset state at the ports
    nchk++;
    if (err_valid !== 1'b0 || err_out !== 16'sd0 || err_branch !== 2'd0) begin
      nfail++;
      $display("FAIL R9: valid=%0b out=%0d branch=%0d expected 0 0 0", err_valid, err_out, err_branch);
    end
    rst = 1'b0;
    mon_en = 1'b1;

    // R1/R2/R3: unit tap at the newest position, table of decisions
    cur_req = "R1/R2/R3";
    wr(7, 1024);
    idle(2);
    for (int i = 0; i < 12; i++) push(int'(VEC[i].y), 1'b1, int'(VEC[i].e));
    idle(6);

    // R4: general taps, correlation order
    cur_req = "R4";
    wr(0, 100); wr(1, -200); wr(2, 300); wr(3, -400);
    wr(4, 500); wr(5, -600); wr(6, 700); wr(7, -800);
    idle(2);
    for (int i = 0; i < 14; i++) push((i * 1237) % 6000 - 3000, 1'b0, 0);
    push(0, 1'b0, 0); push(-1, 1'b0, 0); push(2047, 1'b0, 0);
    idle(6);

    // R5: saturation in both directions
    cur_req = "R5";
    for (int a = 0; a < 8; a++) wr(a, 2047);
    idle(2);
    for (int i = 0; i < 5; i++) push(8191, 1'b0, 0);
    for (int i = 0; i < 5; i++) push(-8192, 1'b0, 0);
    push(5000, 1'b0, 0);
    idle(6);

    // R8: writes under freeze are ignored, later writes take effect
    cur_req = "R8";
    @(negedge clk); freeze = 1'b1;
    wr(0, 0); wr(3, -2048); wr(7, 0);
    for (int i = 0; i < 6; i++) push(300 * i - 700, 1'b0, 0);
    idle(4);
    @(negedge clk); freeze = 1'b0;
    for (int a = 0; a < 8; a++) wr(a, 0);
    wr(2, -2048);
    idle(2);
    for (int i = 0; i < 8; i++) push(1100 - 400 * i, 1'b0, 0);
    idle(8);

    mon_en = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule